// File: doc/BRIEF.md
# Attribute Table Structure Checker

This block validates a device attribute table as it streams past, one byte per accepted transfer. A table opens with a fixed 16-byte header. Header bytes 0..3 hold the total size, little-endian. Byte 4 is the revision, byte 5 is a balancing checksum byte, bytes 6..11 are reserved and bytes 12..15 are a sequence number. The header is followed by any number of typed sub-structures. Each sub-structure opens with a 4-byte header: byte 0 is the type code, byte 1 is a reserved byte, and bytes 2..3 are the structure length in bytes, little-endian. The length includes the 4-byte header. The checker does not interpret any other field.

As bytes arrive, the block checks each sub-structure header against the length rule for its type. It keeps a running modulo-256 sum over every byte. It also fills an index memory with the start offset and length of each entry. Entry 0 is always the table header. The block does not use the header's total-size field to find the end of the table. The end comes only from the last marker on the final byte. The outcome is then held on the status outputs until the first byte of the next table is accepted. The index can be read at any time through an asynchronous read port.

Error codes (`err_code`) are:
- 0: none
- 1: reserved byte nonzero
- 2: zero length
- 3: reserved type
- 4: illegal length for the type
- 5: truncated table
- 6: index full
- 7: checksum mismatch

Top module: `attr_table_checker`

## Requirements
- R1: The 16 header bytes (offsets 0..15) form index entry 0 with start 0 and length 16, and `entry_count` then includes it; a passing table always reports at least one entry.
- R2: Every sub-structure that passes its header checks is written to the next index entry with its start offset in the table and its length field (byte 2 low, byte 3 high), and `entry_count` rises by exactly one per entry.
- R3: Types 0, 1 and 4 must have length 24, type 2 length 20 and type 3 length 8; any other length gives code 4.
- R4: Type 5 must have length of at least 16 with (length − 16) a multiple of 8; otherwise code 4.
- R5: A type code above 5 gives code 3. After any error, the remaining bytes of the table are consumed without adding entries.
- R6: The sub-header checks apply in a fixed priority: a nonzero reserved byte (code 1) first, then a zero length (code 2), then a reserved type (code 3), then an illegal length (code 4).
- R7: When no other error occurred, a nonzero 8-bit sum of all table bytes gives code 7.
- R8: If the last marker arrives anywhere other than on the final byte of the header (when no sub-structures follow) or on the final byte of a sub-structure, the result is code 5.
- R9: The index holds DEPTH entries (64 by default). A sub-structure that finds the index full gives code 6 and is not indexed.
- R10: `done` rises in the cycle after the last byte is accepted and holds until the next table's first byte is accepted. `pass` equals `done` with code 0. The first error detected in a table is the one reported.
- R11: `in_ready` is high in every cycle after the first clock edge out of reset, and a new table starts with cleared state immediately after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte valid |
| in_data | input | 8 | Table byte |
| in_last | input | 1 | Marks the final byte of a table |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| done | output | 1 | Table finished; status valid |
| pass | output | 1 | Table finished without error |
| err_code | output | 3 | First error of the table (codes above) |
| entry_count | output | $clog2(DEPTH+1) | Number of index entries written |
| idx_addr | input | $clog2(DEPTH) | Index read address |
| idx_start | output | OFS_W | Start offset of the addressed entry |
| idx_len | output | 16 | Length of the addressed entry |

## Verification
Clean tables mixing every legal type, including a variable-length type-5 structure, show that offsets and lengths land in the right index slots. Tables that break exactly one rule are checked against its code. Tables that break several rules at once separate the priority between checks in the same header from the priority of earlier errors over later ones. Tables cut short inside the header, a sub-header or a body, with 63 and 64 sub-structures and with an off-by-one checksum, probe the truncation, full-index and sum boundaries.

// File: rtl/attr_table_checker.sv
module attr_table_checker #(
  parameter int OFS_W = 16,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             done,
  output logic             pass,
  output logic [2:0]       err_code,
  output logic [CW-1:0]    entry_count,
  input  logic [AW-1:0]    idx_addr,
  output logic [OFS_W-1:0] idx_start,
  output logic [15:0]      idx_len
);

  typedef enum logic [1:0] {PH_HDR, PH_SUB, PH_BODY} phase_t;

  localparam logic [2:0] E_NONE  = 3'd0;
  localparam logic [2:0] E_RSVD  = 3'd1;
  localparam logic [2:0] E_ZLEN  = 3'd2;
  localparam logic [2:0] E_TYPE  = 3'd3;
  localparam logic [2:0] E_SIZE  = 3'd4;
  localparam logic [2:0] E_TRUNC = 3'd5;
  localparam logic [2:0] E_OVFL  = 3'd6;
  localparam logic [2:0] E_SUM   = 3'd7;
  localparam int HDR_BYTES = 16;

  logic [OFS_W-1:0] pos_q;
  phase_t           ph_q;
  logic [1:0]       sb_q;
  logic [7:0]       typ_q, rsv_q, lo_q, sum_q;
  logic [15:0]      rem_q;
  logic [2:0]       err_q;
  logic [CW-1:0]    cnt_q;
  logic             idle_q, done_q, rdy_q;

  logic [OFS_W-1:0] start_mem [DEPTH];
  logic [15:0]      len_mem   [DEPTH];

  wire acc = in_valid & rdy_q;

  wire [OFS_W-1:0] pos_e = idle_q ? '0 : pos_q;
  wire [7:0]       sum_e = idle_q ? 8'd0 : sum_q;
  wire [2:0]       err_e = idle_q ? E_NONE : err_q;
  wire [CW-1:0]    cnt_e = idle_q ? '0 : cnt_q;
  phase_t ph_e;
  assign ph_e = idle_q ? PH_HDR : ph_q;

  wire [7:0]  sum_n   = sum_e + in_data;
  wire [15:0] sub_len = {in_data, lo_q};
  wire hdr_end = (ph_e == PH_HDR) && (pos_e == OFS_W'(HDR_BYTES - 1));
  wire sub_end = (ph_e == PH_SUB) && (sb_q == 2'd3);

  logic size_ok;
  always_comb begin
    case (typ_q)
      8'd0, 8'd1, 8'd4: size_ok = (sub_len == 16'd24);
      8'd2:             size_ok = (sub_len == 16'd20);
      8'd3:             size_ok = (sub_len == 16'd8);
      8'd5:             size_ok = (sub_len >= 16'd16) && (sub_len[2:0] == 3'd0);
      default:          size_ok = 1'b0;
    endcase
  end

  logic [2:0] sub_err;
  always_comb begin
    sub_err = E_NONE;
    if (rsv_q != 8'd0)                sub_err = E_RSVD;
    else if (sub_len == 16'd0)        sub_err = E_ZLEN;
    else if (typ_q > 8'd5)            sub_err = E_TYPE;
    else if (!size_ok)                sub_err = E_SIZE;
    else if (cnt_e == CW'(DEPTH))     sub_err = E_OVFL;
  end

  wire [2:0] err_byte = (err_e != E_NONE) ? err_e : (sub_end ? sub_err : E_NONE);
  wire trunc = (ph_e == PH_HDR && !hdr_end) || (ph_e == PH_SUB) ||
               (ph_e == PH_BODY && rem_q != 16'd1);
  wire [2:0] err_fin = (err_byte != E_NONE) ? err_byte :
                       trunc ? E_TRUNC : (sum_n != 8'd0) ? E_SUM : E_NONE;
  wire [2:0] err_d = in_last ? err_fin : err_byte;

  wire wr_hdr = hdr_end && (err_e == E_NONE);
  wire wr_sub = sub_end && (err_byte == E_NONE);
  wire [AW-1:0] waddr = cnt_e[AW-1:0];

  phase_t     ph_n;
  logic [1:0] sb_n;
  logic [15:0] rem_n;
  always_comb begin
    ph_n  = ph_e;
    sb_n  = sb_q;
    rem_n = rem_q;
    case (ph_e)
      PH_HDR: if (hdr_end) begin
        ph_n = PH_SUB;
        sb_n = 2'd0;
      end
      PH_SUB: begin
        sb_n = sb_q + 2'd1;
        if (sub_end) begin
          ph_n  = PH_BODY;
          rem_n = sub_len - 16'd4;
        end
      end
      default: begin
        rem_n = rem_q - 16'd1;
        sb_n  = 2'd0;
        if (rem_q == 16'd1) ph_n = PH_SUB;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      ph_q   <= PH_HDR;
      sb_q   <= 2'd0;
      typ_q  <= 8'd0;
      rsv_q  <= 8'd0;
      lo_q   <= 8'd0;
      sum_q  <= 8'd0;
      rem_q  <= 16'd0;
      err_q  <= E_NONE;
      cnt_q  <= '0;
      idle_q <= 1'b1;
      done_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      if (acc) begin
        pos_q  <= pos_e + OFS_W'(1);
        sum_q  <= sum_n;
        err_q  <= err_d;
        idle_q <= in_last;
        done_q <= in_last;
        cnt_q  <= cnt_e + CW'(wr_hdr | wr_sub);
        ph_q   <= ph_n;
        sb_q   <= sb_n;
        rem_q  <= rem_n;
        if (ph_e == PH_SUB) begin
          if (sb_q == 2'd0) typ_q <= in_data;
          if (sb_q == 2'd1) rsv_q <= in_data;
          if (sb_q == 2'd2) lo_q  <= in_data;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc && wr_hdr) begin
      start_mem[0] <= '0;
      len_mem[0]   <= 16'(HDR_BYTES);
    end else if (acc && wr_sub) begin
      start_mem[waddr] <= pos_e - OFS_W'(3);
      len_mem[waddr]   <= sub_len;
    end
  end

  assign in_ready    = rdy_q;
  assign done        = done_q;
  assign err_code    = err_q;
  assign pass        = done_q && (err_q == E_NONE);
  assign entry_count = cnt_q;
  assign idx_start   = start_mem[idx_addr];
  assign idx_len     = len_mem[idx_addr];

endmodule

// File: rtl/attr_table_checker_props.sv
module attr_table_checker_props #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_last,
  input logic          done,
  input logic          pass,
  input logic [2:0]    err_code,
  input logic [CW-1:0] entry_count,
  input logic          idle
);

  a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(in_valid && in_ready && in_last));

  a_r10_first_err_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 3'd0 && !idle) |=> (err_code == $past(err_code)));

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    entry_count <= CW'(DEPTH));

  a_r1_pass_has_header: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (entry_count != '0));

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> (entry_count == $past(entry_count) ||
               entry_count == $past(entry_count) + CW'(1)));

endmodule

bind attr_table_checker attr_table_checker_props #(.DEPTH(DEPTH)) u_props (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .done(done), .pass(pass), .err_code(err_code),
  .entry_count(entry_count), .idle(idle_q)
);

// File: tb/attr_table_checker_test.sv
`timescale 1ns/1ps
module attr_table_checker_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic [5:0] idx_addr = 6'd0;
  logic in_ready, done, pass;
  logic [2:0] err_code;
  logic [6:0] entry_count;
  logic [15:0] idx_start, idx_len;

  attr_table_checker uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .done(done), .pass(pass),
    .err_code(err_code), .entry_count(entry_count), .idx_addr(idx_addr),
    .idx_start(idx_start), .idx_len(idx_len)
  );

  int checks = 0, errors = 0;
  typedef struct { logic [2:0] err; int cnt; string tag; } exp_t;
  exp_t expq[$];
  logic [7:0] tbl[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    logic prev;
    exp_t e;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (done && !prev) begin
        if (expq.size() == 0) check(1'b0, "R10", "unexpected done", 1, 0);
        else begin
          e = expq.pop_front();
          check(err_code == e.err, e.tag, "err_code", err_code, e.err);
          check(entry_count == e.cnt, e.tag, "entry_count", entry_count, e.cnt);
          check(pass == (e.err == 3'd0), e.tag, "pass", pass, e.err == 3'd0);
        end
      end
      prev = done;
    end
  end

  task automatic add_hdr();
    repeat (16) tbl.push_back(8'd0);
    tbl[4] = 8'd1;
    tbl[12] = 8'h44; tbl[13] = 8'h33; tbl[14] = 8'h22; tbl[15] = 8'h11;
  endtask

  task automatic add_sub(input logic [7:0] t, input logic [7:0] r, input int len);
    tbl.push_back(t);
    tbl.push_back(r);
    tbl.push_back(len[7:0]);
    tbl.push_back(len[15:8]);
    for (int k = 4; k < len; k++) tbl.push_back(8'(k * 3 + int'(t)));
  endtask

  task automatic seal(input int bump);
    int n = tbl.size();
    logic [7:0] s = 8'd0;
    tbl[0] = n[7:0]; tbl[1] = n[15:8]; tbl[2] = n[23:16]; tbl[3] = n[31:24];
    tbl[5] = 8'd0;
    foreach (tbl[i]) s += tbl[i];
    tbl[5] = 8'(-int'(s) + bump);
  endtask

  task automatic send(input logic [2:0] err, input int cnt, input string tag);
    exp_t e;
    e.err = err; e.cnt = cnt; e.tag = tag;
    expq.push_back(e);
    foreach (tbl[i]) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = tbl[i];
      in_last  = (i == tbl.size() - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    repeat (2) @(negedge clk);
    tbl.delete();
  endtask

  task automatic chk_idx(input int a, input int st, input int ln, input string req);
    @(negedge clk);
    idx_addr = 6'(a);
    #1;
    check(idx_start == st, req, "idx_start", idx_start, st);
    check(idx_len == ln, req, "idx_len", idx_len, ln);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state and R11 ready
    check(done == 1'b0, "R10", "reset done", done, 0);
    check(pass == 1'b0, "R10", "reset pass", pass, 0);
    check(err_code == 3'd0, "R10", "reset err", err_code, 0);
    check(entry_count == 7'd0, "R1", "reset count", entry_count, 0);
    check(in_ready == 1'b1, "R11", "ready after reset", in_ready, 1);

    // R1 header only
    add_hdr(); seal(0); send(3'd0, 1, "R1");
    chk_idx(0, 0, 16, "R1");

    // R2 R3 R4 mixed legal structures
    add_hdr(); add_sub(8'd0, 8'd0, 24); add_sub(8'd3, 8'd0, 8); add_sub(8'd5, 8'd0, 32);
    seal(0); send(3'd0, 4, "R2");
    chk_idx(1, 16, 24, "R2");
    chk_idx(2, 40, 8, "R2");
    chk_idx(3, 48, 32, "R4");

    add_hdr(); add_sub(8'd2, 8'd0, 20); add_sub(8'd4, 8'd0, 24); add_sub(8'd1, 8'd0, 24);
    add_sub(8'd5, 8'd0, 16);
    seal(0); send(3'd0, 5, "R3");
    chk_idx(4, 84, 16, "R4");

    // R3 wrong fixed lengths
    add_hdr(); add_sub(8'd2, 8'd0, 24); seal(0); send(3'd4, 1, "R3");
    add_hdr(); add_sub(8'd3, 8'd0, 24); seal(0); send(3'd4, 1, "R3");

    // R4 type 5 bad lengths
    add_hdr(); add_sub(8'd5, 8'd0, 20); seal(0); send(3'd4, 1, "R4");
    add_hdr(); add_sub(8'd5, 8'd0, 8); seal(0); send(3'd4, 1, "R4");

    // R5 reserved type, later bytes ignored
    add_hdr(); add_sub(8'd9, 8'd0, 8); add_sub(8'd3, 8'd0, 8); seal(0); send(3'd3, 1, "R5");
    add_hdr(); add_sub(8'd3, 8'd0, 8); add_sub(8'd6, 8'd0, 8); seal(0); send(3'd3, 2, "R5");

    // R6 priorities
    add_hdr(); add_sub(8'd7, 8'd1, 0); seal(0); send(3'd1, 1, "R6");
    add_hdr(); add_sub(8'd9, 8'd0, 0); seal(0); send(3'd2, 1, "R6");
    add_hdr(); add_sub(8'd8, 8'd0, 20); seal(0); send(3'd3, 1, "R6");

    // R7 checksum off by one
    add_hdr(); add_sub(8'd3, 8'd0, 8); seal(1); send(3'd7, 2, "R7");
    add_hdr(); seal(255); send(3'd7, 1, "R7");

    // R10 first error kept over bad sum
    add_hdr(); add_sub(8'd6, 8'd0, 8); seal(5); send(3'd3, 1, "R10");

    // R8 truncation in body, header and sub-header
    add_hdr(); add_sub(8'd0, 8'd0, 24); seal(0);
    repeat (5) void'(tbl.pop_back());
    send(3'd5, 2, "R8");
    add_hdr(); seal(0);
    repeat (6) void'(tbl.pop_back());
    send(3'd5, 0, "R8");
    add_hdr(); add_sub(8'd3, 8'd0, 8); seal(0);
    repeat (6) void'(tbl.pop_back());
    send(3'd5, 1, "R8");

    // R9 index full boundary
    add_hdr(); for (int k = 0; k < 63; k++) add_sub(8'd3, 8'd0, 8); seal(0);
    send(3'd0, 64, "R9");
    chk_idx(63, 512, 8, "R9");
    add_hdr(); for (int k = 0; k < 64; k++) add_sub(8'd3, 8'd0, 8); seal(0);
    send(3'd6, 64, "R9");

    // R11 restart after error table
    add_hdr(); seal(0); send(3'd0, 1, "R11");

    check(expq.size() == 0, "R10", "pending results", expq.size(), 0);
    finish_run();
  end
endmodule